// File: doc/BRIEF.md
# Chip-Select Region Decoder

This block maps a 30-bit system address onto one of eight external device regions. Each region has a configuration word that gives its base in 16 MiB units, a 4-bit size mask and an enable bit. It also has a device word whose type field says what kind of part sits behind the region. A matching address produces a one-hot chip-select, a route code and the address offset inside the region. The route code picks one of three ports: the plain memory port for NOR-style parts, the NAND data port, or the prefetch FIFO port. The FIFO port is chosen when the prefetch engine is switched on and points at the matching region.

Configuration is written and read through a simple word-wide port. Decoding is purely combinational from the registered configuration. A write therefore changes the decode result from the clock edge that captures it onward. A region that is enabled but has a size mask the block does not support raises a per-region error flag. It still decodes.

Top module: `cs_region_decoder`

## Requirements
- R1: After reset every region configuration word reads 0x0000_0F00, except region 0, which reads 0x0000_0F40. Every device word and the prefetch word read 0.
- R2: A write stores only the defined bits. These are 0xF7F of a region configuration word (index 2r), bits 11:10 of a device word (index 2r+1), and bits 26:24 and 7 of the prefetch word (index 16). Reads of any other index return 0.
- R3: Region r matches when its enable bit (bit 6) is set, address bits 29:28 equal base bits 5:4, and address bits 27:24 equal base bits 3:0 in every position where the mask (bits 11:8) holds a 1.
- R4: A region whose enable bit is clear never matches, whatever its base and mask.
- R5: When several regions match, the lowest index wins. On a miss, the chip-select is all zero, the route code is 0 and the offset is 0.
- R6: On a hit, the offset equals address bits 23:0, with address bits 27:24 ANDed with the inverted mask of the selected region placed above them.
- R7: A hit on a region whose device type (device word bits 11:10) is 0 gives route code 1, the memory port.
- R8: A hit on a region with a non-zero device type gives route code 3, the FIFO port, when the prefetch enable (bit 7) is set and the prefetch region field (bits 26:24) equals the region index. Otherwise it gives route code 2, the NAND port.
- R9: The error flag of a region is 1 exactly when the region is enabled and its mask is none of 0x8, 0xC, 0xE, 0xF. A mask of 0x0 is also accepted when ALLOW_FULL_MASK is 1.
- R10: A configuration write leaves the decode unchanged up to the capturing clock edge. The decode reflects the write from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | 5 | Configuration word index to write |
| cfg_wr_data | input | 32 | Configuration write data |
| cfg_rd_addr | input | 5 | Configuration word index to read |
| cfg_rd_data | output | 32 | Configuration read data (combinational) |
| sys_addr | input | 30 | System address to decode |
| cs_onehot | output | 8 | One-hot chip-select of the winning region |
| route | output | 2 | 0 none, 1 memory, 2 NAND data, 3 prefetch FIFO |
| region_offset | output | 28 | Offset of the address inside the selected region |
| mask_err | output | 8 | Per-region unsupported-mask flag |

## Verification
The hardest case is an address that several regions claim at once while their device types and the prefetch setting differ. Only then do the priority and the FIFO steering interact, for example when the prefetch engine points at a region that loses the priority contest. The stimulus builds overlapping regions of different sizes, including a disabled region and one with an unsupported mask. It then sweeps every value of the top six address bits under three prefetch settings and compares each result with a model the bench keeps of the written configuration.

// File: rtl/csdec_pkg.sv
package csdec_pkg;

    localparam int SYS_AW  = 30;
    localparam int OFF_W   = 28;
    localparam int WORD_W  = 32;
    localparam int PFCS_W  = 3;

    typedef enum logic [1:0] {
        RT_NONE = 2'd0,
        RT_MEM  = 2'd1,
        RT_NAND = 2'd2,
        RT_FIFO = 2'd3
    } route_e;

    // supported size masks: 128, 64, 32, 16 MiB; 0 (256 MiB) optional
    function automatic logic mask_supported(input logic [3:0] m, input logic allow_full);
        case (m)
            4'h8, 4'hC, 4'hE, 4'hF: mask_supported = 1'b1;
            4'h0:                   mask_supported = allow_full;
            default:                mask_supported = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/csdec_cfg_regs.sv
module csdec_cfg_regs
    import csdec_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int IDX_W       = 5
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  logic [WORD_W-1:0]                 wr_data,
    input  logic [IDX_W-1:0]                  rd_idx,
    output logic [WORD_W-1:0]                 rd_data,
    output logic [NUM_REGIONS-1:0][11:0]      map_cfg,
    output logic [NUM_REGIONS-1:0][1:0]       dev_type,
    output logic                              pf_en,
    output logic [PFCS_W-1:0]                 pf_sel
);

    localparam int PF_IDX = 2 * NUM_REGIONS;

    typedef struct packed {
        logic [NUM_REGIONS-1:0][11:0] map;
        logic [NUM_REGIONS-1:0][1:0]  dtype;
        logic                         pf_en;
        logic [PFCS_W-1:0]            pf_sel;
    } cfg_t;

    cfg_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            for (int r = 0; r < NUM_REGIONS; r++) begin
                if (wr_idx == IDX_W'(2 * r))
                    state_d.map[r] = wr_data[11:0] & 12'hF7F;
                if (wr_idx == IDX_W'(2 * r + 1))
                    state_d.dtype[r] = wr_data[11:10];
            end
            if (wr_idx == IDX_W'(PF_IDX)) begin
                state_d.pf_en  = wr_data[7];
                state_d.pf_sel = wr_data[26:24];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_REGIONS; r++) begin
                state_q.map[r]   <= (r == 0) ? 12'hF40 : 12'hF00;
                state_q.dtype[r] <= 2'd0;
            end
            state_q.pf_en  <= 1'b0;
            state_q.pf_sel <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int r = 0; r < NUM_REGIONS; r++) begin
            if (rd_idx == IDX_W'(2 * r))
                rd_data = {20'd0, state_q.map[r]};
            if (rd_idx == IDX_W'(2 * r + 1))
                rd_data = {20'd0, state_q.dtype[r], 10'd0};
        end
        if (rd_idx == IDX_W'(PF_IDX))
            rd_data = {5'd0, state_q.pf_sel, 16'd0, state_q.pf_en, 7'd0};
    end

    assign map_cfg  = state_q.map;
    assign dev_type = state_q.dtype;
    assign pf_en    = state_q.pf_en;
    assign pf_sel   = state_q.pf_sel;

    AST_MAP0_WRITE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == '0) |=> (map_cfg[0] == ($past(wr_data[11:0]) & 12'hF7F))); // R2

    AST_IDLE_HOLDS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(map_cfg) && $stable(dev_type) && $stable(pf_en) && $stable(pf_sel))); // R10

endmodule

// File: rtl/csdec_region_match.sv
module csdec_region_match
    import csdec_pkg::*;
#(
    parameter int   NUM_REGIONS     = 8,
    parameter logic ALLOW_FULL_MASK = 1'b0
) (
    input  logic [SYS_AW-1:0]            addr,
    input  logic [NUM_REGIONS-1:0][11:0] map_cfg,
    input  logic [NUM_REGIONS-1:0][1:0]  dev_type,
    input  logic                         pf_en,
    input  logic [PFCS_W-1:0]            pf_sel,
    output logic [NUM_REGIONS-1:0]       hit_vec,
    output logic [NUM_REGIONS-1:0][1:0]  route_vec,
    output logic [NUM_REGIONS-1:0]       bad_mask
);

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
        logic [5:0] base;
        logic [3:0] msk;
        logic       enabled;
        logic       top_eq;
        logic       low_eq;

        assign base    = map_cfg[r][5:0];
        assign msk     = map_cfg[r][11:8];
        assign enabled = map_cfg[r][6];
        assign top_eq  = (addr[29:28] == base[5:4]);
        assign low_eq  = (((addr[27:24] ^ base[3:0]) & msk) == 4'h0);

        assign hit_vec[r]  = enabled && top_eq && low_eq;
        assign bad_mask[r] = enabled && !mask_supported(msk, ALLOW_FULL_MASK);

        always_comb begin
            if (dev_type[r] == 2'd0)
                route_vec[r] = RT_MEM;
            else if (pf_en && (pf_sel == PFCS_W'(r)))
                route_vec[r] = RT_FIFO;
            else
                route_vec[r] = RT_NAND;
        end
    end

endmodule

// File: rtl/csdec_priority_sel.sv
module csdec_priority_sel
    import csdec_pkg::*;
#(
    parameter int NUM_REGIONS = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [SYS_AW-1:0]            addr,
    input  logic [NUM_REGIONS-1:0]       hit_vec,
    input  logic [NUM_REGIONS-1:0][1:0]  route_vec,
    input  logic [NUM_REGIONS-1:0][11:0] map_cfg,
    output logic [NUM_REGIONS-1:0]       cs_onehot,
    output logic [1:0]                   route,
    output logic [OFF_W-1:0]             offset
);

    logic found;

    always_comb begin
        found     = 1'b0;
        cs_onehot = '0;
        route     = RT_NONE;
        offset    = '0;
        for (int r = 0; r < NUM_REGIONS; r++) begin
            if (!found && hit_vec[r]) begin
                found        = 1'b1;
                cs_onehot[r] = 1'b1;
                route        = route_vec[r];
                offset       = {addr[27:24] & ~map_cfg[r][11:8], addr[23:0]};
            end
        end
    end

    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_onehot)); // R5

    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_vec == '0) |-> (cs_onehot == '0 && route == RT_NONE && offset == '0)); // R5

endmodule

// File: rtl/cs_region_decoder.sv
module cs_region_decoder
    import csdec_pkg::*;
#(
    parameter int   NUM_REGIONS     = 8,
    parameter logic ALLOW_FULL_MASK = 1'b0,
    parameter int   IDX_W           = $clog2(2 * NUM_REGIONS + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_wr_en,
    input  logic [IDX_W-1:0]       cfg_wr_addr,
    input  logic [31:0]            cfg_wr_data,
    input  logic [IDX_W-1:0]       cfg_rd_addr,
    output logic [31:0]            cfg_rd_data,
    input  logic [29:0]            sys_addr,
    output logic [NUM_REGIONS-1:0] cs_onehot,
    output logic [1:0]             route,
    output logic [27:0]            region_offset,
    output logic [NUM_REGIONS-1:0] mask_err
);

    logic [NUM_REGIONS-1:0][11:0] map_cfg;
    logic [NUM_REGIONS-1:0][1:0]  dev_type;
    logic                         pf_en;
    logic [PFCS_W-1:0]            pf_sel;
    logic [NUM_REGIONS-1:0]       hit_vec;
    logic [NUM_REGIONS-1:0][1:0]  route_vec;

    csdec_cfg_regs #(.NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W)) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr_en),
        .wr_idx   (cfg_wr_addr),
        .wr_data  (cfg_wr_data),
        .rd_idx   (cfg_rd_addr),
        .rd_data  (cfg_rd_data),
        .map_cfg  (map_cfg),
        .dev_type (dev_type),
        .pf_en    (pf_en),
        .pf_sel   (pf_sel)
    );

    csdec_region_match #(.NUM_REGIONS(NUM_REGIONS), .ALLOW_FULL_MASK(ALLOW_FULL_MASK)) i_match (
        .addr      (sys_addr),
        .map_cfg   (map_cfg),
        .dev_type  (dev_type),
        .pf_en     (pf_en),
        .pf_sel    (pf_sel),
        .hit_vec   (hit_vec),
        .route_vec (route_vec),
        .bad_mask  (mask_err)
    );

    csdec_priority_sel #(.NUM_REGIONS(NUM_REGIONS)) i_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (sys_addr),
        .hit_vec   (hit_vec),
        .route_vec (route_vec),
        .map_cfg   (map_cfg),
        .cs_onehot (cs_onehot),
        .route     (route),
        .offset    (region_offset)
    );

    AST_FIFO_NEEDS_PF: assert property (@(posedge clk) disable iff (!rst_n)
        (route == RT_FIFO) |-> pf_en); // R8

    AST_HIT_HAS_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_onehot != '0) |-> (route != RT_NONE)); // R7

    logic [NUM_REGIONS-1:0] valid_bits;
    always_comb
        for (int r = 0; r < NUM_REGIONS; r++) valid_bits[r] = map_cfg[r][6];

    AST_ERR_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        ((mask_err & ~valid_bits) == '0)); // R9

    AST_CS_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        ((cs_onehot & ~valid_bits) == '0)); // R4

endmodule

// File: tb/test_cs_region_decoder.sv
module test_cs_region_decoder;

    localparam int N      = 8;
    localparam int IW     = 5;
    localparam int PF_IDX = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr_en = 1'b0;
    logic [IW-1:0] cfg_wr_addr = '0;
    logic [31:0]   cfg_wr_data = '0;
    logic [IW-1:0] cfg_rd_addr = '0;
    logic [31:0]   cfg_rd_data;
    logic [29:0]   sys_addr = '0;
    logic [N-1:0]  cs_onehot;
    logic [1:0]    route;
    logic [27:0]   region_offset;
    logic [N-1:0]  mask_err;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [11:0] m_map [N];
    logic [1:0]  m_dt  [N];
    logic        m_pfen;
    logic [2:0]  m_pfcs;

    always #4 clk = ~clk;

    cs_region_decoder i_cs_region_decoder (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_addr(cfg_rd_addr), .cfg_rd_data(cfg_rd_data),
        .sys_addr(sys_addr), .cs_onehot(cs_onehot), .route(route),
        .region_offset(region_offset), .mask_err(mask_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_addr = IW'(idx); cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        if (idx < 2 * N && idx % 2 == 0) m_map[idx/2] = d[11:0] & 12'hF7F;
        if (idx < 2 * N && idx % 2 == 1) m_dt[idx/2] = d[11:10];
        if (idx == PF_IDX) begin m_pfen = d[7]; m_pfcs = d[26:24]; end
    endtask

    task automatic rd_check(input string req, input int idx, input logic [31:0] exp);
        @(negedge clk);
        cfg_rd_addr = IW'(idx);
        #1;
        check(req, cfg_rd_data, exp);
    endtask

    task automatic dec_check(input string req, input logic [29:0] a);
        logic [N-1:0] e_cs;
        logic [1:0]   e_rt;
        logic [27:0]  e_off;
        bit           f;
        e_cs = '0; e_rt = 2'd0; e_off = '0; f = 0;
        for (int r = 0; r < N; r++) begin
            if (!f && m_map[r][6] && a[29:28] == m_map[r][5:4] &&
                ((a[27:24] ^ m_map[r][3:0]) & m_map[r][11:8]) == 4'h0) begin
                f = 1;
                e_cs[r] = 1'b1;
                if (m_dt[r] == 2'd0) e_rt = 2'd1;
                else if (m_pfen && m_pfcs == 3'(r)) e_rt = 2'd3;
                else e_rt = 2'd2;
                e_off = {a[27:24] & ~m_map[r][11:8], a[23:0]};
            end
        end
        sys_addr = a;
        #1;
        check({req, " cs R3 R4 R5"}, 32'(cs_onehot), 32'(e_cs));
        check({req, " route R7 R8"}, 32'(route), 32'(e_rt));
        check({req, " offset R6"}, 32'(region_offset), 32'(e_off));
    endtask

    task automatic err_check(input string req);
        logic [N-1:0] e;
        for (int r = 0; r < N; r++) begin
            logic [3:0] m;
            m = m_map[r][11:8];
            e[r] = m_map[r][6] && !(m == 4'h8 || m == 4'hC || m == 4'hE || m == 4'hF);
        end
        #1;
        check(req, 32'(mask_err), 32'(e));
    endtask

    task automatic sweep(input string req);
        logic [23:0] lows [3];
        lows[0] = 24'h000000; lows[1] = 24'hABCDEF; lows[2] = 24'hFFFFFF;
        for (int hi = 0; hi < 64; hi++)
            for (int l = 0; l < 3; l++) begin
                @(negedge clk);
                dec_check(req, {6'(hi), lows[l]});
            end
    endtask

    initial begin
        for (int r = 0; r < N; r++) begin
            m_map[r] = (r == 0) ? 12'hF40 : 12'hF00;
            m_dt[r]  = 2'd0;
        end
        m_pfen = 1'b0; m_pfcs = 3'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset contents
        for (int r = 0; r < N; r++) begin
            rd_check("R1 map word", 2 * r, (r == 0) ? 32'h0F40 : 32'h0F00);
            rd_check("R1 device word", 2 * r + 1, 32'h0);
        end
        rd_check("R1 prefetch word", PF_IDX, 32'h0);
        @(negedge clk); dec_check("R1 reset decode hit", 30'h00123456);
        @(negedge clk); dec_check("R1 reset decode miss", 30'h01000000);
        err_check("R1 R9 reset flags");

        // R2: write masking and readback
        wr(6, 32'hFFFF_FFFF); rd_check("R2 map keep", 6, 32'h0F7F);
        wr(7, 32'hFFFF_FFFF); rd_check("R2 device keep", 7, 32'h0C00);
        wr(PF_IDX, 32'hFFFF_FFFF); rd_check("R2 prefetch keep", PF_IDX, 32'h0700_0080);
        rd_check("R2 unused index", 17, 32'h0);
        wr(PF_IDX, 32'h0); wr(6, 32'h0F00); wr(7, 32'h0);

        // R9: mask legality sweep on region 3
        for (int m = 0; m < 16; m++) begin
            wr(6, 32'(m << 8) | 32'h40);
            err_check("R9 enabled mask sweep");
            wr(6, 32'(m << 8));
            err_check("R9 disabled mask sweep");
        end

        // overlapping configuration
        wr(0,  32'h0F40);                 wr(1,  32'h0000);
        wr(2,  32'h0848);                 wr(3,  32'h0800);
        wr(4,  32'h0C4C);                 wr(5,  32'h0800);
        wr(6,  32'h0E60);                 wr(7,  32'h0000);
        wr(8,  32'h0F30);                 wr(9,  32'h0000);
        wr(10, 32'h0F71);                 wr(11, 32'h0C00);
        wr(12, 32'h0854);                 wr(13, 32'h0800);
        wr(14, 32'h007F);                 wr(15, 32'h0000);
        err_check("R9 overlap config flags");

        wr(PF_IDX, 32'h0200_0080); sweep("R8 pf on region2");
        wr(PF_IDX, 32'h0100_0080); sweep("R8 pf on region1");
        wr(PF_IDX, 32'h0500_0000); sweep("R8 pf off");

        // R10: region 4 enabled by a write; 0x30 previously served by region 7
        @(negedge clk);
        sys_addr = 30'h30000000;
        cfg_wr_en = 1'b1; cfg_wr_addr = IW'(8); cfg_wr_data = 32'h0F70;
        #1;
        check("R10 before edge", 32'(cs_onehot), 32'h80);
        @(negedge clk);
        cfg_wr_en = 1'b0;
        m_map[4] = 12'hF70;
        #1;
        check("R10 after edge", 32'(cs_onehot), 32'h10);
        @(negedge clk); dec_check("R10 decode after write", 30'h30ABCDEF);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule